// File: doc/BRIEF.md
# Equalizer Settings Bus Slave

This block is the write-only control port of a five-band stereo tone processor. It watches a two-wire serial bus (SCL and SDA), answers frames addressed to it, and keeps one control byte per band. For each band it presents a boost step and a cut step (0 to 5) to the analog section. A global defeat flag forces every band to neutral while the stored settings are kept.

A host writes a frame with a start condition, the device address, a register index and one or more data bytes, then a stop condition. Each data byte goes to the band that the index selects, and the index then moves on to the next band. The slave pulls SDA low for acknowledge slots only. It never stretches the clock and never returns data.

Bus sequencing is held in one enumerated state machine. Its states are IDLE, ADDR, ADDR_ACK, SUB, SUB_ACK, DATA, DATA_ACK and SKIP. A detected start moves any state to ADDR, and a detected stop moves any state to IDLE. IDLE ignores the bus. ADDR goes to ADDR_ACK on an address hit and to SKIP on a miss, once the eighth bit is followed by a falling SCL. ADDR_ACK goes to SUB on the next falling SCL. SUB goes to SUB_ACK after eight bits, and SUB_ACK goes to DATA on the next falling SCL. DATA goes to DATA_ACK after eight bits, and DATA_ACK goes back to DATA on the next falling SCL. SKIP ignores the bus until the next start or stop.

Top module: `eq_ctrl_slave`

## Requirements
- R1: The 8-bit address byte 0x84 is acknowledged when `addr_sel` is 0. The byte 0x86 is acknowledged when `addr_sel` is 1. Acknowledge means `sda_oe` = 1 during the ninth clock of the byte.
- R2: A read request (address bit 0 = 1) or any other address byte gets no acknowledge. No byte that follows it in the same frame is acknowledged or stored.
- R3: After a matching address, the next byte is a register index. Index values 0 to 4 select band 1 to band 5. The first data byte is stored to the selected band, and register outputs change only while SCL is low.
- R4: Each further data byte in the same frame goes to the index plus one, so consecutive bands are written in one frame.
- R5: In a data byte, bits 6:4 are the boost code and bits 2:0 are the cut code. Bit 3 has no effect. Band *k* appears on `boost_steps[3k+2:3k]` and `cut_steps[3k+2:3k]`, where k = 0 is band 1.
- R6: Codes 0 to 4 give steps 0 to 4. Codes 5, 6 and 7 all give step 5, and no output field ever exceeds 5.
- R7: Bit 7 of the band-1 byte is the defeat flag, shown on `defeat`. While it is 1, all boost and cut outputs read 0. The stored codes reappear when it returns to 0. Bit 7 of the other bands has no effect.
- R8: After reset, `defeat` = 1, all stored codes are 0, `sda_oe` = 0, and the bus receiver is idle.
- R9: An index above 4 is acknowledged but writes nothing. Data bytes whose index has passed 4 are acknowledged and discarded.
- R10: A repeated start in mid-frame abandons the frame and starts address matching again.
- R11: A stop condition in the middle of a data byte discards the partial byte.
- R12: `sda_oe` only rises or falls while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, sampled |
| sda_in | input | 1 | Bus data line, sampled |
| addr_sel | input | 1 | Strap that selects the device address (0: 0x84, 1: 0x86) |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| defeat | output | 1 | Stored defeat flag |
| boost_steps | output | 15 | Effective boost step, 3 bits per band, band 1 in the low bits |
| cut_steps | output | 15 | Effective cut step, 3 bits per band, band 1 in the low bits |

## Verification
Two functions can meet in the same register update. The first is the defeat override together with a new boost and cut code for band 1. The second is an auto-increment write together with the index stepping past the last band. The bench provokes the first with one byte that sets defeat and saturating codes at once. It judges the result by checking that every band reads zero, and that the stored codes come back once a later byte clears defeat. It provokes the second with a three-byte burst that starts at band 4. There, the scoreboard expects all three acknowledges, and the outputs show that only bands 4 and 5 changed.

// File: rtl/eq_ctrl_pkg.sv
package eq_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } bus_state_t;

    localparam int BYTE_W     = 8;
    localparam int BOOST_LSB  = 4;
    localparam int CUT_LSB    = 0;
    localparam int DEFEAT_BIT = 7;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_pipe, sda_pipe;
    logic         scl_q, sda_q;
    logic         scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[MSB-1:0], scl_in};
            sda_pipe <= {sda_pipe[MSB-1:0], sda_in};
            scl_q    <= scl_pipe[MSB];
            sda_q    <= sda_pipe[MSB];
        end
    end

    assign scl_s     = scl_pipe[MSB];
    assign sda_s     = sda_pipe[MSB];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
    import eq_ctrl_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR_LO = 8'h84,
    parameter logic [7:0] DEV_ADDR_HI = 8'h86,
    parameter int         NUM_REGS    = 5,
    parameter int         STEP_W      = 3,
    localparam int        IDX_W       = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_sel,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [STEP_W-1:0] wr_boost,
    output logic [STEP_W-1:0] wr_cut,
    output logic              wr_defeat
);
    localparam logic [3:0]        BIT_LAST = 4'(BYTE_W);
    localparam logic [BYTE_W-1:0] PTR_MAX  = '1;
    localparam logic [BYTE_W-1:0] PTR_LIM  = BYTE_W'(NUM_REGS);

    bus_state_t        state, nxt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic [3:0]        bitcnt;
    logic              byte_done;
    logic              receiving;
    logic              in_ack;
    logic              addr_hit;

    assign byte_done = scl_fall && (bitcnt == BIT_LAST);
    assign receiving = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign in_ack    = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) || (state == ST_DATA_ACK);
    assign addr_hit  = (shreg == (addr_sel ? DEV_ADDR_HI : DEV_ADDR_LO));

    // next-state logic
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_ADDR;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall)  nxt = ST_SUB;
                ST_SUB:      if (byte_done) nxt = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall)  nxt = ST_DATA;
                ST_DATA:     if (byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  nxt = ST_DATA;
                ST_SKIP:     nxt = ST_SKIP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift register, bit counter and index pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            ptr    <= '0;
        end else if (start_det || stop_det) begin
            bitcnt <= '0;
        end else begin
            if (receiving && scl_rise && (bitcnt != BIT_LAST)) begin
                shreg  <= {shreg[BYTE_W-2:0], sda_s};
                bitcnt <= bitcnt + 4'd1;
            end
            if (in_ack && scl_fall) begin
                bitcnt <= '0;
            end
            if ((state == ST_SUB) && byte_done) begin
                ptr <= shreg;
            end
            if ((state == ST_DATA) && byte_done && (ptr != PTR_MAX)) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe    = in_ack;
        wr_en     = (state == ST_DATA) && byte_done && (ptr < PTR_LIM);
        wr_idx    = ptr[IDX_W-1:0];
        wr_boost  = shreg[BOOST_LSB +: STEP_W];
        wr_cut    = shreg[CUT_LSB +: STEP_W];
        wr_defeat = shreg[DEFEAT_BIT];
    end

endmodule

// File: rtl/eq_band_regs.sv
module eq_band_regs #(
    parameter int  NUM_BANDS = 5,
    parameter int  STEP_W    = 3,
    parameter int  MAX_STEP  = 5,
    localparam int IDX_W     = $clog2(NUM_BANDS),
    localparam int OUT_W     = NUM_BANDS * STEP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [STEP_W-1:0] wr_boost,
    input  logic [STEP_W-1:0] wr_cut,
    input  logic              wr_defeat,
    output logic              defeat,
    output logic [OUT_W-1:0]  boost_steps,
    output logic [OUT_W-1:0]  cut_steps
);
    localparam logic [STEP_W-1:0] LIM = STEP_W'(MAX_STEP);

    logic [NUM_BANDS-1:0][STEP_W-1:0] boost_q, cut_q;
    logic                             defeat_q;

    function automatic logic [STEP_W-1:0] clip(input logic [STEP_W-1:0] code);
        return (code > LIM) ? LIM : code;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boost_q  <= '0;
            cut_q    <= '0;
            defeat_q <= 1'b1;
        end else if (wr_en) begin
            for (int b = 0; b < NUM_BANDS; b++) begin
                if (wr_idx == IDX_W'(b)) begin
                    boost_q[b] <= wr_boost;
                    cut_q[b]   <= wr_cut;
                end
            end
            if (wr_idx == '0) defeat_q <= wr_defeat;
        end
    end

    assign defeat = defeat_q;

    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
        assign boost_steps[g*STEP_W +: STEP_W] = defeat_q ? '0 : clip(boost_q[g]);
        assign cut_steps[g*STEP_W +: STEP_W]   = defeat_q ? '0 : clip(cut_q[g]);
    end

endmodule

// File: rtl/eq_ctrl_slave.sv
module eq_ctrl_slave #(
    parameter int         NUM_BANDS   = 5,
    parameter int         STEP_W      = 3,
    parameter int         MAX_STEP    = 5,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] DEV_ADDR_LO = 8'h84,
    parameter logic [7:0] DEV_ADDR_HI = 8'h86,
    localparam int        IDX_W       = $clog2(NUM_BANDS),
    localparam int        OUT_W       = NUM_BANDS * STEP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             addr_sel,
    output logic             sda_oe,
    output logic             defeat,
    output logic [OUT_W-1:0] boost_steps,
    output logic [OUT_W-1:0] cut_steps
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en, wr_defeat;
    logic [IDX_W-1:0]  wr_idx;
    logic [STEP_W-1:0] wr_boost, wr_cut;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_wr_fsm #(
        .DEV_ADDR_LO(DEV_ADDR_LO), .DEV_ADDR_HI(DEV_ADDR_HI),
        .NUM_REGS(NUM_BANDS), .STEP_W(STEP_W)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_boost(wr_boost), .wr_cut(wr_cut), .wr_defeat(wr_defeat)
    );

    eq_band_regs #(
        .NUM_BANDS(NUM_BANDS), .STEP_W(STEP_W), .MAX_STEP(MAX_STEP)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_boost(wr_boost), .wr_cut(wr_cut), .wr_defeat(wr_defeat),
        .defeat(defeat), .boost_steps(boost_steps), .cut_steps(cut_steps)
    );

endmodule

// File: rtl/eq_ctrl_slave_chk.sv
module eq_ctrl_slave_chk #(
    parameter int  NUM_BANDS = 5,
    parameter int  STEP_W    = 3,
    parameter int  MAX_STEP  = 5,
    localparam int OUT_W     = NUM_BANDS * STEP_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             sda_oe,
    input logic             defeat,
    input logic [OUT_W-1:0] boost_steps,
    input logic [OUT_W-1:0] cut_steps
);
    AST_DEFEAT_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
        defeat |-> (boost_steps == '0 && cut_steps == '0)); // R7

    AST_ACK_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_in); // R12

    AST_ACK_RELEASE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_in); // R12

    AST_UPDATE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({defeat, boost_steps, cut_steps}) |-> !scl_in); // R3

    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_lim
        AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            (boost_steps[g*STEP_W +: STEP_W] <= STEP_W'(MAX_STEP)) &&
            (cut_steps[g*STEP_W +: STEP_W] <= STEP_W'(MAX_STEP))); // R6
    end

endmodule

bind eq_ctrl_slave eq_ctrl_slave_chk #(
    .NUM_BANDS(NUM_BANDS), .STEP_W(STEP_W), .MAX_STEP(MAX_STEP)
) chk_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
    .defeat(defeat), .boost_steps(boost_steps), .cut_steps(cut_steps)
);

// File: tb/eq_ctrl_slave_tb.sv
module eq_ctrl_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int NB         = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b0;
    logic        sda_oe, defeat;
    logic [14:0] boost_steps, cut_steps;
    logic        sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    eq_ctrl_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .addr_sel(addr_sel), .sda_oe(sda_oe), .defeat(defeat),
        .boost_steps(boost_steps), .cut_steps(cut_steps)
    );

    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    bit         ack_q[$];
    logic       ack_strobe = 1'b0;
    string      cur_tag = "";
    logic [7:0] m_reg [NB];
    logic [7:0] tx [8];

    function automatic logic [2:0] step_of(input logic [2:0] c);
        return (c > 3'd4) ? 3'd5 : c;
    endfunction

    // scoreboard monitor: compares each acknowledge slot with the queued expectation
    always @(posedge ack_strobe) begin
        bit exp_ack;
        n_checks++;
        if (ack_q.size() == 0) begin
            n_fail++;
            $display("FAIL %s: ack slot with empty queue actual=%0d expected=queued", cur_tag, sda_oe);
        end else begin
            exp_ack = ack_q.pop_front();
            if (sda_oe !== exp_ack) begin
                n_fail++;
                $display("FAIL %s: ack actual=%0d expected=%0d", cur_tag, sda_oe, exp_ack);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        ack_q.push_back(exp_ack);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack_strobe = 1'b1; tick(Q);
        ack_strobe = 1'b0;
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic check_outputs(input string tag);
        logic       exp_def;
        logic [2:0] eb, ec;
        exp_def = m_reg[0][7];
        n_checks++;
        if (defeat !== exp_def) begin
            n_fail++;
            $display("FAIL %s: defeat actual=%0d expected=%0d", tag, defeat, exp_def);
        end
        for (int b = 0; b < NB; b++) begin
            eb = exp_def ? 3'd0 : step_of(m_reg[b][6:4]);
            ec = exp_def ? 3'd0 : step_of(m_reg[b][2:0]);
            n_checks++;
            if (boost_steps[b*3 +: 3] !== eb || cut_steps[b*3 +: 3] !== ec) begin
                n_fail++;
                $display("FAIL %s: band %0d boost/cut actual=%0d/%0d expected=%0d/%0d",
                         tag, b + 1, boost_steps[b*3 +: 3], cut_steps[b*3 +: 3], eb, ec);
            end
        end
    endtask

    // one full write frame with n data bytes from tx[]
    task automatic frame(input logic [7:0] a, input logic [7:0] sub, input int n, input string tag);
        bit match;
        int p;
        cur_tag = tag;
        match = (a == (addr_sel ? 8'h86 : 8'h84));
        bus_start();
        send_byte(a, match);
        send_byte(sub, match);
        p = sub;
        for (int i = 0; i < n; i++) begin
            send_byte(tx[i], match);
            if (match) begin
                if (p < NB) m_reg[p] = tx[i];
                if (p != 255) p++;
            end
        end
        bus_stop();
        tick(4);
        check_outputs(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        m_reg[0] = 8'h80;
        for (int b = 1; b < NB; b++) m_reg[b] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R8: reset state
        n_checks++;
        if (sda_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL R8: sda_oe actual=%0d expected=0", sda_oe);
        end
        check_outputs("R8");

        // R1, R3: low strap address, clear defeat on band 1
        tx[0] = 8'h00; frame(8'h84, 8'h00, 1, "R1");
        // R3, R5: band 2, then same codes with bit 3 set
        tx[0] = 8'h32; frame(8'h84, 8'h01, 1, "R3");
        tx[0] = 8'h3A; frame(8'h84, 8'h01, 1, "R5");
        // R4: burst over bands 3..5
        tx[0] = 8'h41; tx[1] = 8'h14; tx[2] = 8'h23;
        frame(8'h84, 8'h02, 3, "R4");
        // R6: saturating codes 5,7 then 7,6
        tx[0] = 8'h57; frame(8'h84, 8'h00, 1, "R6");
        tx[0] = 8'h76; frame(8'h84, 8'h00, 1, "R6");
        // R7: defeat with new codes, then release; bit 7 of band 3 has no effect
        tx[0] = 8'hD3; frame(8'h84, 8'h00, 1, "R7");
        tx[0] = 8'h53; frame(8'h84, 8'h00, 1, "R7");
        tx[0] = 8'hA2; frame(8'h84, 8'h02, 1, "R7");
        // R2: wrong address and read request ignored
        tx[0] = 8'h00; frame(8'h86, 8'h01, 1, "R2");
        tx[0] = 8'h00; frame(8'h85, 8'h01, 1, "R2");
        // R1: high strap
        addr_sel = 1'b1; tick(4);
        tx[0] = 8'h44; frame(8'h86, 8'h03, 1, "R1");
        tx[0] = 8'h00; frame(8'h84, 8'h03, 1, "R1");
        // R9: index above range, and burst running past last band
        tx[0] = 8'hFF; frame(8'h86, 8'h07, 1, "R9");
        tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33;
        frame(8'h86, 8'h03, 3, "R9");
        addr_sel = 1'b0; tick(4);

        // R10: repeated start abandons frame; mismatched restart ignored
        cur_tag = "R10";
        bus_start();
        send_byte(8'h84, 1'b1);
        send_byte(8'h02, 1'b1);
        bus_start();
        send_byte(8'h85, 1'b0);
        send_byte(8'h77, 1'b0);
        bus_stop();
        tick(4);
        check_outputs("R10");
        // R10: repeated start into a valid frame
        bus_start();
        send_byte(8'h84, 1'b1);
        send_byte(8'h03, 1'b1);
        bus_start();
        send_byte(8'h84, 1'b1);
        send_byte(8'h01, 1'b1);
        send_byte(8'h24, 1'b1);
        m_reg[1] = 8'h24;
        bus_stop();
        tick(4);
        check_outputs("R10");

        // R11: stop after four data bits
        cur_tag = "R11";
        bus_start();
        send_byte(8'h84, 1'b1);
        send_byte(8'h01, 1'b1);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        tick(4);
        check_outputs("R11");
        // R11: receiver still usable after the aborted byte
        tx[0] = 8'h15; frame(8'h84, 8'h01, 1, "R11");

        n_checks++;
        if (ack_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1: pending ack slots actual=%0d expected=0", ack_q.size());
        end
        finish_run();
    end

endmodule